// File: doc/BRIEF.md
# Reconfigurable Slot Swap Sequencer

This block steps one reconfigurable processing slot through the exchange of its engine. When a swap is requested it first isolates the slot by dropping the enable of the interface macros and holding the engine in reset. It then prepares the configuration port and starts an external bitstream streamer. It waits for the streamer's completion interrupt, acknowledges it, and can optionally run a verification pass. Only after that does it release reset, perform an initialization handshake with the new engine and reconnect the slot.

The block is meant for a video pipeline that has a fixed time per frame. A frame lasts 40 ms at 25 frames per second, and no frame may be lost. A swap can happen once in the idle gap between two frames. Several swaps can also run back to back inside one frame, so that successive engines share the same slot. A cycle budget, loaded at each start, bounds the two waits on external agents: the streamer interrupt and the verification result. A swap that overruns the budget is aborted and leaves the slot isolated. Sticky error and verification-fail flags report the outcome until the next accepted start.

Top module: `slot_swap_seq`

## Requirements
- R1: After reset, macro_en_o=0, eng_rst_o=1, busy_o=0, err_o=0, fail_o=0, and every step strobe is 0.
- R2: start_i is acted on only when busy_o=0. A start while busy_o=1 changes neither the running sequence nor any output.
- R3: After an accepted start, the steps run in a fixed order, one step per cycle. The isolate step comes first (busy_o=1, macro_en_o=0). Next is the reset step (eng_rst_o=1), then one cycle of cport_cfg_o, then one cycle of strm_go_o. The block then waits for strm_irq_i. After strm_irq_i it gives one cycle of irq_ack_o.
- R4: macro_en_o stays 0 from the isolate step through the end of engine initialization. eng_rst_o stays 1 from the reset step through the end of verification.
- R5: verify_en_i is sampled with the accepted start. When it was 1, vrfy_go_o pulses for one cycle after irq_ack_o. The block then waits for vrfy_done_i and takes vrfy_ok_i in that same cycle.
- R6: When verify_en_i was 0 at start, vrfy_go_o never pulses, and the release step directly follows irq_ack_o.
- R7: In the release step eng_rst_o drops to 0. Then init_req_o stays 1 until eng_ready_i is seen. One cycle follows with done_o=1 and macro_en_o=1. After that busy_o=0, and macro_en_o=1 and eng_rst_o=0 stay until the next start.
- R8: If vrfy_done_i arrives with vrfy_ok_i=0, fail_o goes to 1 and stays set. The slot stays isolated (macro_en_o=0, eng_rst_o=1), and busy_o returns to 0 one cycle later.
- R9: A counter is loaded with BUDGET_CYC when a start is accepted, and it counts down on every busy cycle. If it reaches 0 while the block waits for strm_irq_i or vrfy_done_i, err_o goes to 1 and stays set. The slot stays isolated and the block returns to idle.
- R10: An accepted start clears fail_o and err_o. The flags read 0 from the isolate step onward.
- R11: A strm_irq_i arriving in the same cycle that the budget runs out is honoured: irq_ack_o follows and err_o is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Swap request |
| verify_en_i | input | 1 | Run a verification pass on this swap (sampled at start) |
| strm_irq_i | input | 1 | Streamer completion interrupt |
| vrfy_done_i | input | 1 | Verification result valid |
| vrfy_ok_i | input | 1 | Verification passed (with vrfy_done_i) |
| eng_ready_i | input | 1 | New engine finished initialization |
| macro_en_o | output | 1 | Enable of the slot's interface macros |
| eng_rst_o | output | 1 | Engine reset |
| cport_cfg_o | output | 1 | One-cycle configuration-port setup strobe |
| strm_go_o | output | 1 | One-cycle streamer start strobe |
| irq_ack_o | output | 1 | One-cycle interrupt acknowledge |
| vrfy_go_o | output | 1 | One-cycle verification start strobe |
| init_req_o | output | 1 | Engine initialization request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle successful-completion pulse |
| fail_o | output | 1 | Sticky verification-failure flag |
| err_o | output | 1 | Sticky budget-overrun flag |

## Verification
Swaps are run with verification disabled and enabled, with a passing and a failing result, and with different streamer and engine delays. Comparing these runs separates the bypass path from the verify path, and it separates the success path from the path that leaves the slot fenced off. The streamer interrupt is placed exactly on the last budget cycle and one cycle later, which pins down the expiry boundary. A silent verifier exercises the second timeout point. Start pulses are sent while a swap is running, and swaps are started right after one completes, to show that back-to-back swaps inside a frame work and that stray requests are dropped.

// File: rtl/slot_swap_pkg.sv
package slot_swap_pkg;
  typedef enum logic [3:0] {
    S_IDLE     = 4'd0,
    S_ISOLATE  = 4'd1,
    S_HOLDRST  = 4'd2,
    S_PORTSET  = 4'd3,
    S_LOAD     = 4'd4,
    S_WAIT_IRQ = 4'd5,
    S_ACK      = 4'd6,
    S_VGO      = 4'd7,
    S_VWAIT    = 4'd8,
    S_RELEASE  = 4'd9,
    S_INIT     = 4'd10,
    S_ENABLE   = 4'd11,
    S_FAIL     = 4'd12,
    S_TMO      = 4'd13
  } swap_st_e;
endpackage

// File: rtl/swap_budget_timer.sv
module swap_budget_timer #(
  parameter int unsigned BUDGET_CYC = 5000000
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(BUDGET_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUDGET_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= LOAD_VAL;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/swap_step_fsm.sv
module swap_step_fsm
  import slot_swap_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start_i,
  input  logic     verify_en_i,
  input  logic     strm_irq_i,
  input  logic     vrfy_done_i,
  input  logic     vrfy_ok_i,
  input  logic     eng_ready_i,
  input  logic     expired_i,
  output swap_st_e state_q,
  output swap_st_e state_d,
  output logic     accept_o
);
  logic ven_q;

  assign accept_o = (state_q == S_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (start_i) state_d = S_ISOLATE;
      S_ISOLATE:  state_d = S_HOLDRST;
      S_HOLDRST:  state_d = S_PORTSET;
      S_PORTSET:  state_d = S_LOAD;
      S_LOAD:     state_d = S_WAIT_IRQ;
      S_WAIT_IRQ: begin
        if (strm_irq_i)     state_d = S_ACK;
        else if (expired_i) state_d = S_TMO;
      end
      S_ACK:      state_d = ven_q ? S_VGO : S_RELEASE;
      S_VGO:      state_d = S_VWAIT;
      S_VWAIT: begin
        if (vrfy_done_i)    state_d = vrfy_ok_i ? S_RELEASE : S_FAIL;
        else if (expired_i) state_d = S_TMO;
      end
      S_RELEASE:  state_d = S_INIT;
      S_INIT:     if (eng_ready_i) state_d = S_ENABLE;
      S_ENABLE:   state_d = S_IDLE;
      S_FAIL:     state_d = S_IDLE;
      S_TMO:      state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      ven_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) ven_q <= verify_en_i;
    end
  end
endmodule

// File: rtl/swap_out_reg.sv
module swap_out_reg
  import slot_swap_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  swap_st_e state_q,
  input  swap_st_e state_d,
  output logic     macro_en_o,
  output logic     eng_rst_o,
  output logic     cport_cfg_o,
  output logic     strm_go_o,
  output logic     irq_ack_o,
  output logic     vrfy_go_o,
  output logic     init_req_o,
  output logic     busy_o,
  output logic     done_o,
  output logic     fail_o,
  output logic     err_o
);
  logic live_q, live_d;
  logic fail_d, err_d;
  logic run_phase;

  always_comb begin
    live_d = live_q;
    if (state_q == S_ENABLE)      live_d = 1'b1;
    else if (state_d == S_HOLDRST) live_d = 1'b0;

    fail_d = fail_o;
    err_d  = err_o;
    if (state_q == S_IDLE && state_d == S_ISOLATE) begin
      fail_d = 1'b0;
      err_d  = 1'b0;
    end
    if (state_d == S_FAIL) fail_d = 1'b1;
    if (state_d == S_TMO)  err_d  = 1'b1;

    run_phase = (state_d == S_RELEASE) || (state_d == S_INIT) ||
                (state_d == S_ENABLE) ||
                (((state_d == S_IDLE) || (state_d == S_ISOLATE)) && live_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q      <= 1'b0;
      macro_en_o  <= 1'b0;
      eng_rst_o   <= 1'b1;
      cport_cfg_o <= 1'b0;
      strm_go_o   <= 1'b0;
      irq_ack_o   <= 1'b0;
      vrfy_go_o   <= 1'b0;
      init_req_o  <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      live_q      <= live_d;
      macro_en_o  <= (state_d == S_ENABLE) || ((state_d == S_IDLE) && live_d);
      eng_rst_o   <= !run_phase;
      cport_cfg_o <= (state_d == S_PORTSET);
      strm_go_o   <= (state_d == S_LOAD);
      irq_ack_o   <= (state_d == S_ACK);
      vrfy_go_o   <= (state_d == S_VGO);
      init_req_o  <= (state_d == S_INIT);
      busy_o      <= (state_d != S_IDLE);
      done_o      <= (state_d == S_ENABLE);
      fail_o      <= fail_d;
      err_o       <= err_d;
    end
  end
endmodule

// File: rtl/slot_swap_seq.sv
module slot_swap_seq
  import slot_swap_pkg::*;
#(
  parameter int unsigned BUDGET_CYC = 5000000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic verify_en_i,
  input  logic strm_irq_i,
  input  logic vrfy_done_i,
  input  logic vrfy_ok_i,
  input  logic eng_ready_i,
  output logic macro_en_o,
  output logic eng_rst_o,
  output logic cport_cfg_o,
  output logic strm_go_o,
  output logic irq_ack_o,
  output logic vrfy_go_o,
  output logic init_req_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o,
  output logic err_o
);
  swap_st_e state_q, state_d;
  logic     accept, expired;

  swap_step_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .verify_en_i (verify_en_i),
    .strm_irq_i  (strm_irq_i),
    .vrfy_done_i (vrfy_done_i),
    .vrfy_ok_i   (vrfy_ok_i),
    .eng_ready_i (eng_ready_i),
    .expired_i   (expired),
    .state_q     (state_q),
    .state_d     (state_d),
    .accept_o    (accept)
  );

  swap_budget_timer #(.BUDGET_CYC(BUDGET_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (accept),
    .run_i     (state_q != S_IDLE),
    .expired_o (expired)
  );

  swap_out_reg u_out (
    .clk         (clk),
    .rst         (rst),
    .state_q     (state_q),
    .state_d     (state_d),
    .macro_en_o  (macro_en_o),
    .eng_rst_o   (eng_rst_o),
    .cport_cfg_o (cport_cfg_o),
    .strm_go_o   (strm_go_o),
    .irq_ack_o   (irq_ack_o),
    .vrfy_go_o   (vrfy_go_o),
    .init_req_o  (init_req_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/slot_swap_chk.sv
module slot_swap_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic strm_irq_i,
  input logic macro_en_o,
  input logic eng_rst_o,
  input logic cport_cfg_o,
  input logic strm_go_o,
  input logic irq_ack_o,
  input logic vrfy_go_o,
  input logic init_req_o,
  input logic busy_o,
  input logic done_o,
  input logic fail_o,
  input logic err_o
);
  // R3: step strobes never overlap
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cport_cfg_o, strm_go_o, irq_ack_o, vrfy_go_o, init_req_o, done_o}));

  // R3: configuration-port setup is directly followed by the streamer start
  p_port_then_go_r3: assert property (@(posedge clk) disable iff (rst)
    cport_cfg_o |=> strm_go_o);

  // R4: slot fenced while the streamer runs
  p_fenced_stream_r4: assert property (@(posedge clk) disable iff (rst)
    (strm_go_o || irq_ack_o || cport_cfg_o) |-> (!macro_en_o && eng_rst_o));

  // R4: isolation is the first visible effect of an accepted start
  p_iso_first_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !macro_en_o);

  // R5: verification start with engine still in reset
  p_vgo_fenced_r5: assert property (@(posedge clk) disable iff (rst)
    vrfy_go_o |-> (eng_rst_o && !macro_en_o && $past(irq_ack_o)));

  // R7: initialization happens out of reset with macros still off
  p_init_state_r7: assert property (@(posedge clk) disable iff (rst)
    init_req_o |-> (!eng_rst_o && !macro_en_o));

  // R7: macros come back only with the completion pulse
  p_enable_done_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(macro_en_o) |-> done_o);

  // R8: a verification failure leaves the slot isolated
  p_fail_fenced_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_o) |-> (eng_rst_o && !macro_en_o && busy_o));

  // R9: an overrun leaves the slot isolated
  p_tmo_fenced_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> (eng_rst_o && !macro_en_o && busy_o));

  // R2: an idle block with no request stays idle
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> !busy_o);
endmodule

bind slot_swap_seq slot_swap_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .strm_irq_i  (strm_irq_i),
  .macro_en_o  (macro_en_o),
  .eng_rst_o   (eng_rst_o),
  .cport_cfg_o (cport_cfg_o),
  .strm_go_o   (strm_go_o),
  .irq_ack_o   (irq_ack_o),
  .vrfy_go_o   (vrfy_go_o),
  .init_req_o  (init_req_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .err_o       (err_o)
);

// File: tb/slot_swap_seq_bench.sv
module slot_swap_seq_bench;
  localparam int BUDGET = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, verify_en_i = 0, strm_irq_i = 0;
  logic vrfy_done_i = 0, vrfy_ok_i = 0, eng_ready_i = 0;
  logic macro_en_o, eng_rst_o, cport_cfg_o, strm_go_o, irq_ack_o, vrfy_go_o;
  logic init_req_o, busy_o, done_o, fail_o, err_o;

  always #4 clk = ~clk;

  slot_swap_seq #(.BUDGET_CYC(BUDGET)) u_slot_swap_seq (.*);

  int checks = 0, fails = 0, cycles = 0;

  // responder settings
  int irq_delay = 3, v_delay = 2, r_delay = 2;
  bit v_pass = 1;
  int icnt = 0, vcnt = 0, rcnt = 0;
  int vgo_seen = 0;

  // behavioural reference: phase names as strings
  string ph = "idle";
  int    left = 0;
  bit    live = 0, ven = 0, mfail = 0, merr = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic string req_of(input string p);
    if (p == "idle") return "R2";
    if (p == "vgo" || p == "vwait") return "R5";
    if (p == "rel" || p == "init" || p == "enable") return "R7";
    if (p == "fail") return "R8";
    if (p == "tmo") return "R9";
    return "R3";
  endfunction

  // reference update at the clock edge (inputs are stable there)
  always @(posedge clk) begin
    if (rst) begin
      ph = "idle"; live = 0; mfail = 0; merr = 0; ven = 0; left = BUDGET;
    end else begin
      string nx;
      bit expd;
      expd = (left == 0);
      if (ph != "idle" && left > 0) left--;
      nx = ph;
      case (ph)
        "idle":   if (start_i) begin nx = "iso"; left = BUDGET; ven = verify_en_i;
                    mfail = 0; merr = 0; end
        "iso":    begin nx = "hrst"; live = 0; end
        "hrst":   nx = "port";
        "port":   nx = "go";
        "go":     nx = "wirq";
        "wirq":   if (strm_irq_i) nx = "ack"; else if (expd) nx = "tmo";
        "ack":    nx = ven ? "vgo" : "rel";
        "vgo":    nx = "vwait";
        "vwait":  if (vrfy_done_i) nx = vrfy_ok_i ? "rel" : "fail";
                  else if (expd) nx = "tmo";
        "rel":    nx = "init";
        "init":   if (eng_ready_i) nx = "enable";
        "enable": begin nx = "idle"; live = 1; end
        default:  nx = "idle";
      endcase
      if (nx == "fail") mfail = 1;
      if (nx == "tmo")  merr = 1;
      ph = nx;
    end
  end

  // per-cycle comparison and responders, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      bit busy_e, run_e;
      string r;
      r = req_of(ph);
      busy_e = (ph != "idle");
      run_e  = (ph == "rel" || ph == "init" || ph == "enable" ||
                ((ph == "idle" || ph == "iso") && live));
      chk(r, "busy_o",      busy_o,      busy_e);
      chk("R4", "macro_en_o", macro_en_o, (ph == "enable") || (ph == "idle" && live));
      chk("R4", "eng_rst_o",  eng_rst_o,  !run_e);
      chk(r, "cport_cfg_o", cport_cfg_o, ph == "port");
      chk(r, "strm_go_o",   strm_go_o,   ph == "go");
      chk(r, "irq_ack_o",   irq_ack_o,   ph == "ack");
      chk(r, "vrfy_go_o",   vrfy_go_o,   ph == "vgo");
      chk(r, "init_req_o",  init_req_o,  ph == "init");
      chk(r, "done_o",      done_o,      ph == "enable");
      chk("R10", "fail_o",  fail_o,      mfail);
      chk("R10", "err_o",   err_o,       merr);
    end
    if (vrfy_go_o) vgo_seen++;
    // streamer
    strm_irq_i = 0;
    if (strm_go_o) icnt = irq_delay;
    else if (icnt > 0) begin icnt--; if (icnt == 0) strm_irq_i = 1; end
    // verifier
    vrfy_done_i = 0; vrfy_ok_i = 0;
    if (vrfy_go_o) vcnt = v_delay;
    else if (vcnt > 0) begin vcnt--; if (vcnt == 0) begin vrfy_done_i = 1; vrfy_ok_i = v_pass; end end
    // engine
    if (!init_req_o) begin rcnt = 0; eng_ready_i = 0; end
    else begin rcnt++; if (rcnt >= r_delay) eng_ready_i = 1; end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic kick(input bit v);
    @(negedge clk); start_i = 1; verify_en_i = v;
    @(negedge clk); start_i = 0; verify_en_i = 0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "macro_en after reset", macro_en_o, 0);
    chk("R1", "eng_rst after reset",  eng_rst_o, 1);
    chk("R1", "busy after reset",     busy_o, 0);
    chk("R1", "flags after reset",    {fail_o, err_o}, 0);
    repeat (2) @(negedge clk);

    // swap without verification, stray starts while busy (R2, R3, R6, R7)
    irq_delay = 5; r_delay = 3; vgo_seen = 0;
    kick(0);
    repeat (3) @(negedge clk);
    start_i = 1; @(negedge clk); start_i = 0;
    wait_idle();
    chk("R6", "vrfy_go pulses without verification", vgo_seen, 0);
    chk("R7", "macro_en kept after swap", macro_en_o, 1);
    chk("R7", "eng_rst released after swap", eng_rst_o, 0);
    repeat (3) @(negedge clk);
    chk("R2", "no second sequence from busy start", busy_o, 0);

    // swap with passing verification, back to back (intra-frame) (R5)
    irq_delay = 2; v_delay = 4; v_pass = 1; vgo_seen = 0;
    kick(1);
    wait_idle();
    chk("R5", "one vrfy_go pulse", vgo_seen, 1);
    kick(1);
    wait_idle();
    chk("R5", "second swap completes", macro_en_o, 1);

    // verification failure (R8), then cleared by next start (R10)
    v_pass = 0; v_delay = 1;
    kick(1);
    wait_idle();
    chk("R8", "fail_o set", fail_o, 1);
    chk("R8", "slot isolated after fail", {macro_en_o, eng_rst_o}, 2'b01);
    v_pass = 1;
    kick(0);
    chk("R10", "fail cleared by start", fail_o, 0);
    wait_idle();

    // interrupt one cycle late -> overrun (R9)
    irq_delay = BUDGET - 2;
    kick(0);
    wait_idle();
    chk("R9", "err_o on late interrupt", err_o, 1);
    chk("R9", "slot isolated after overrun", {macro_en_o, eng_rst_o}, 2'b01);

    // interrupt exactly on the last budget cycle (R11), also clears err (R10)
    irq_delay = BUDGET - 3;
    kick(0);
    chk("R10", "err cleared by start", err_o, 0);
    wait_idle();
    chk("R11", "no err at boundary", err_o, 0);
    chk("R11", "swap completes at boundary", macro_en_o, 1);

    // silent verifier -> overrun during verify wait (R9)
    irq_delay = 2; v_delay = 1000;
    kick(1);
    wait_idle();
    chk("R9", "err_o on missing verify result", err_o, 1);
    v_delay = 2;
    repeat (5) @(negedge clk);
    chk("R2", "late verify result ignored", {busy_o, fail_o}, 2'b00);

    finish_run();
  end
endmodule